// File: doc/BRIEF.md
# Bus Wake-Up Pattern Filter

This block is the digital mode controller of a two-wire differential bus transceiver. It takes a sampled bus-state bit (dominant or recessive), a transmit bit and a standby-select pin. In the active mode it turns the transmit bit into a driver enable and turns the bus state into a receive output. In the low-power mode it keeps the driver off and holds the receive output recessive. Meanwhile it watches the bus for a filtered wake-up pattern.

A wake-up is accepted only after three phases in order: a long enough dominant phase, then a long enough recessive phase, then a long enough dominant phase. Once that pattern is seen, the receive output follows the bus, so that the host controller can notice the traffic and select the active mode again. A bus held dominant, short spikes, phases that end too early and a pattern that takes too long are all rejected. Every duration is a parameter counted in clock cycles. The raw bus bit passes through a synchroniser before any counting is done.

Top module: `bus_wake_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters standby with the wake flag cleared. `drv_en` reads 0 and `rx_out` reads 1 after that edge.
- R2: `stby_sel` = 0 selects the active (normal) mode and `stby_sel` = 1 selects standby. The pin is registered once before it takes effect.
- R3: In normal mode, `drv_en` equals the inverse of `tx_bit` one clock after `tx_bit` is sampled (`tx_bit` = 0 drives dominant, `drv_en` = 1).
- R4: In normal mode, `rx_out` is 0 when the bus is dominant (`bus_dom` = 1) and 1 when it is recessive. A change on `bus_dom` reaches `rx_out` after exactly three clock edges: two synchroniser stages and one output register.
- R5: In standby, `drv_en` stays 0 whatever `tx_bit` does.
- R6: In standby, before a wake-up, `rx_out` stays 1 whatever the bus does.
- R7: A wake-up is detected after at least `T_DOM` dominant samples, then at least `T_REC` recessive samples, then `T_DOM` dominant samples. After detection, `rx_out` follows the bus as in R4.
- R8: A first dominant phase shorter than `T_DOM` samples restarts the search.
- R9: A recessive phase shorter than `T_REC` samples sends the detector back to waiting for a first dominant phase.
- R10: A bus held dominant, or repeated dominant spikes shorter than `T_DOM`, never produce a wake-up.
- R11: If the rest of the pattern does not complete within `T_TMO` cycles after the first valid dominant phase ends, the detector resets.
- R12: Entering normal mode clears the wake flag. The next standby entry starts with `rx_out` held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_sel | input | 1 | 1 = standby, 0 = normal |
| tx_bit | input | 1 | Transmit data, 0 = dominant |
| bus_dom | input | 1 | Raw sampled bus state, 1 = dominant |
| drv_en | output | 1 | Driver enable, 1 = drive dominant |
| rx_out | output | 1 | Receive data, 0 = dominant |

## Verification
The bench drives phases of exactly the minimum length, and phases one sample short of it, to find off-by-one errors in the phase counters. A design with such an error would either miss a legal pattern or accept one that is too short. A recessive gap that is too short, a long stall before the final dominant phase, a stream of spikes and a clamped dominant bus are each applied to a detector that should not wake. A detector missing the gap rule, the timeout or the spike filter would release `rx_out` early. The bench also leaves standby with a wake-up pending and then re-enters standby on a dominant bus. A design that failed to clear the flag would show `rx_out` low at once.

// File: rtl/bus_wake_pkg.sv
package bus_wake_pkg;
  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_DOM1  = 3'd1,
    WK_REC   = 3'd2,
    WK_DOM2  = 3'd3,
    WK_AWAKE = 3'd4
  } wk_state_t;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } op_mode_t;
endpackage

// File: rtl/bus_wake_sync.sv
module bus_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[i] <= 1'b0;
          else     sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect
  import bus_wake_pkg::*;
#(
  parameter int T_DOM = 8,
  parameter int T_REC = 8,
  parameter int T_TMO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bus_s,
  output logic woke
);
  localparam int PH_MAX = (T_DOM > T_REC) ? T_DOM : T_REC;
  localparam int CNT_W  = $clog2(PH_MAX + 1) + 1;
  localparam int TMO_W  = $clog2(T_TMO + 1) + 1;
  localparam logic [CNT_W-1:0] DOM_MIN  = CNT_W'(T_DOM);
  localparam logic [CNT_W-1:0] DOM_LAST = CNT_W'(T_DOM - 1);
  localparam logic [CNT_W-1:0] REC_MIN  = CNT_W'(T_REC);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(T_TMO - 1);

  wk_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st  <= WK_IDLE;
      cnt <= '0;
      tmo <= '0;
    end else begin
      case (st)
        WK_IDLE: begin
          if (bus_s) begin
            st  <= WK_DOM1;
            cnt <= CNT_W'(1);
          end
        end
        WK_DOM1: begin
          if (bus_s) begin
            if (cnt < DOM_MIN) cnt <= cnt + 1'b1;
          end else if (cnt >= DOM_MIN) begin
            st  <= WK_REC;
            cnt <= CNT_W'(1);
            tmo <= '0;
          end else begin
            st  <= WK_IDLE;
            cnt <= '0;
          end
        end
        WK_REC: begin
          tmo <= tmo + 1'b1;
          if (tmo >= TMO_LAST) begin
            st  <= WK_IDLE;
            cnt <= '0;
          end else if (!bus_s) begin
            if (cnt < REC_MIN) cnt <= cnt + 1'b1;
          end else if (cnt >= REC_MIN) begin
            st  <= WK_DOM2;
            cnt <= CNT_W'(1);
          end else begin
            st  <= WK_IDLE;
            cnt <= '0;
          end
        end
        WK_DOM2: begin
          tmo <= tmo + 1'b1;
          if (tmo >= TMO_LAST) begin
            st  <= WK_IDLE;
            cnt <= '0;
          end else if (bus_s) begin
            if (cnt >= DOM_LAST) st <= WK_AWAKE;
            else                 cnt <= cnt + 1'b1;
          end else begin
            st  <= WK_IDLE;
            cnt <= '0;
          end
        end
        WK_AWAKE: st <= WK_AWAKE;
        default: begin
          st  <= WK_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign woke = (st == WK_AWAKE);
endmodule

// File: rtl/bus_wake_mode.sv
module bus_wake_mode
  import bus_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stby_sel,
  input  logic tx_bit,
  input  logic bus_s,
  input  logic woke,
  output logic mode_stby,
  output logic drv_en,
  output logic rx_out
);
  op_mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_STANDBY;
    else     mode_q <= stby_sel ? MODE_STANDBY : MODE_NORMAL;
  end

  assign mode_stby = (mode_q == MODE_STANDBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en <= 1'b0;
      rx_out <= 1'b1;
    end else if (mode_stby) begin
      drv_en <= 1'b0;
      rx_out <= woke ? !bus_s : 1'b1;
    end else begin
      drv_en <= !tx_bit;
      rx_out <= !bus_s;
    end
  end
endmodule

// File: rtl/bus_wake_ctrl.sv
module bus_wake_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int T_DOM       = 8,
  parameter int T_REC       = 8,
  parameter int T_TMO       = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_sel,
  input  logic tx_bit,
  input  logic bus_dom,
  output logic drv_en,
  output logic rx_out
);
  logic bus_s;
  logic woke;
  logic mode_stby;

  bus_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_dom),
    .q   (bus_s)
  );

  bus_wake_detect #(.T_DOM(T_DOM), .T_REC(T_REC), .T_TMO(T_TMO)) u_det (
    .clk   (clk),
    .rst   (rst),
    .en    (mode_stby),
    .bus_s (bus_s),
    .woke  (woke)
  );

  bus_wake_mode u_mode (
    .clk       (clk),
    .rst       (rst),
    .stby_sel  (stby_sel),
    .tx_bit    (tx_bit),
    .bus_s     (bus_s),
    .woke      (woke),
    .mode_stby (mode_stby),
    .drv_en    (drv_en),
    .rx_out    (rx_out)
  );
endmodule

// File: rtl/bus_wake_ctrl_chk.sv
module bus_wake_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tx_bit,
  input logic drv_en,
  input logic rx_out,
  input logic mode_stby,
  input logic woke,
  input logic bus_s
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!drv_en && rx_out));

  // R3
  tx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_stby |=> (drv_en == !$past(tx_bit)));

  // R5
  stby_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mode_stby |=> !drv_en);

  // R6
  stby_rx_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_stby && !woke) |=> rx_out);

  // R10
  wake_on_dom_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(woke) |-> $past(bus_s));

  // R12
  normal_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_stby |=> !woke);
endmodule

bind bus_wake_ctrl bus_wake_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_bit    (tx_bit),
  .drv_en    (drv_en),
  .rx_out    (rx_out),
  .mode_stby (mode_stby),
  .woke      (woke),
  .bus_s     (bus_s)
);

// File: tb/bus_wake_ctrl_tb.sv
`timescale 1ns/1ps
module bus_wake_ctrl_tb;
  localparam int T_DOM = 8;
  localparam int T_REC = 8;
  localparam int T_TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_sel = 1'b0;
  logic tx_bit = 1'b0;
  logic bus_dom = 1'b0;
  logic drv_en;
  logic rx_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_wake_ctrl #(.SYNC_STAGES(2), .T_DOM(T_DOM), .T_REC(T_REC), .T_TMO(T_TMO)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .stby_sel (stby_sel),
    .tx_bit   (tx_bit),
    .bus_dom  (bus_dom),
    .drv_en   (drv_en),
    .rx_out   (rx_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_for(input logic v, input int n);
    bus_dom = v;
    cyc(n);
  endtask

  task automatic rearm();
    bus_dom  = 1'b0;
    stby_sel = 1'b0;
    cyc(5);
    stby_sel = 1'b1;
    cyc(5);
  endtask

  task automatic t_reset();
    rst = 1'b1; stby_sel = 1'b0; tx_bit = 1'b0; bus_dom = 1'b1;
    cyc(3);
    chk(drv_en, 1'b0, "R1 drv_en in reset");
    chk(rx_out, 1'b1, "R1 rx_out in reset");
    bus_dom = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_normal_tx();
    stby_sel = 1'b0;
    cyc(4);
    tx_bit = 1'b1;
    cyc(1);
    chk(drv_en, 1'b0, "R3 tx high -> recessive");
    tx_bit = 1'b0;
    cyc(1);
    chk(drv_en, 1'b1, "R3/R2 tx low -> dominant one clock later");
    tx_bit = 1'b1;
    cyc(1);
  endtask

  task automatic t_normal_rx();
    bus_dom = 1'b1;
    cyc(2);
    chk(rx_out, 1'b1, "R4 rx unchanged after two edges");
    cyc(1);
    chk(rx_out, 1'b0, "R4 rx low after three edges");
    bus_dom = 1'b0;
    cyc(4);
    chk(rx_out, 1'b1, "R4 rx high on recessive");
  endtask

  task automatic t_standby_idle();
    stby_sel = 1'b1;
    tx_bit = 1'b0;
    cyc(4);
    chk(drv_en, 1'b0, "R5/R2 standby ignores tx low");
    bus_dom = 1'b1;
    cyc(4);
    chk(rx_out, 1'b1, "R6 standby rx held high on dominant");
    bus_dom = 1'b0;
    tx_bit = 1'b1;
    cyc(2);
  endtask

  task automatic t_wake_exact();
    rearm();
    bus_for(1'b1, T_DOM);
    bus_for(1'b0, T_REC);
    bus_for(1'b1, T_DOM + 6);
    chk(rx_out, 1'b0, "R7 wake with minimum phases");
    bus_for(1'b0, 4);
    chk(rx_out, 1'b1, "R7 rx follows recessive after wake");
    bus_for(1'b1, 4);
    chk(rx_out, 1'b0, "R7 rx follows dominant after wake");
    chk(drv_en, 1'b0, "R5 no drive while awake in standby");
  endtask

  task automatic t_clear();
    stby_sel = 1'b0;
    cyc(5);
    stby_sel = 1'b1;
    cyc(5);
    chk(rx_out, 1'b1, "R12 wake flag cleared by normal mode");
    bus_dom = 1'b0;
    cyc(2);
  endtask

  task automatic t_short_first();
    rearm();
    bus_for(1'b1, T_DOM - 1);
    bus_for(1'b0, T_REC + 4);
    bus_for(1'b1, T_DOM + 8);
    chk(rx_out, 1'b1, "R8 short first dominant rejected");
  endtask

  task automatic t_short_gap();
    rearm();
    bus_for(1'b1, T_DOM + 4);
    bus_for(1'b0, T_REC - 1);
    bus_for(1'b1, T_DOM + 8);
    chk(rx_out, 1'b1, "R9 short recessive gap rejected");
  endtask

  task automatic t_glitch_clamp();
    rearm();
    for (int i = 0; i < 10; i++) begin
      bus_for(1'b1, 2);
      bus_for(1'b0, T_REC + 1);
    end
    chk(rx_out, 1'b1, "R10 dominant spikes rejected");
    bus_for(1'b1, 6 * T_DOM);
    chk(rx_out, 1'b1, "R10 clamped dominant rejected");
  endtask

  task automatic t_timeout();
    rearm();
    bus_for(1'b1, T_DOM + 2);
    bus_for(1'b0, T_TMO + 5);
    bus_for(1'b1, T_DOM + 8);
    chk(rx_out, 1'b1, "R11 slow pattern times out");
    rearm();
    bus_for(1'b1, T_DOM + 2);
    bus_for(1'b0, T_REC + 4);
    bus_for(1'b1, T_DOM + 8);
    chk(rx_out, 1'b0, "R11/R7 pattern within window wakes");
  endtask

  initial begin
    t_reset();
    t_normal_tx();
    t_normal_rx();
    t_standby_idle();
    t_wake_exact();
    t_clear();
    t_short_first();
    t_short_gap();
    t_glitch_clamp();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule